// File: doc/BRIEF.md
# Cascadable Dual 8-bit Compare Timer

This peripheral holds two 8-bit up-counting timer channels. Each channel has a counter, two compare registers (A and B), a control register and a clock-select register. A channel runs from a prescaled version of the block clock. On every prescaled tick it increments and compares the new value against both compare registers. It can emit one-cycle interrupt pulses on a compare-A match, on a compare-B match and on overflow, and it can clear itself on the compare match that its control register selects.

The two channels can also be chained into one 16-bit timer. In that mode channel 0 holds the upper byte and channel 1 the lower byte. Channel 1's prescaler paces the chain, and the 16-bit compare values are put together in the same way from both channels' compare registers. Software reaches the registers over a simple byte or halfword bus. Read data returns one cycle after the request.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every counter, control register and clock-select register reads 0x00, every compare register reads 0xFF, and all interrupt outputs are low.
- R2: Register address = {register index, channel}. bus_addr[0] selects the channel and bus_addr[3:1] selects the register: 0 control, 1 clock-select, 2 compare A, 3 compare B, 4 counter, 5 status; indices 6 and 7 read 0 and ignore writes. Byte writes take bus_wdata[7:0]. Byte reads return the value in bus_rdata[7:0] with the upper byte 0, one cycle after the request. The control register keeps bits 7:3, the clock-select register keeps bits 4:0, and all other bits read 0.
- R3: A halfword access (bus_hw=1) is accepted only at a channel-0 address of clock-select, compare A, compare B or counter. It writes bus_wdata[15:8] to channel 0 and bus_wdata[7:0] to channel 1, and reads back {channel 0, channel 1}. Any other halfword access changes nothing, and a halfword read of that kind returns 0.
- R4: The channel-1 status register always reads 0x10. Channel 0's status register stores bits 5:4 and reads them back, with the other bits 0.
- R5: The clock-select field bits 2:0 pick the divide ratio (codes 1 to 7 give 1, 2, 8, 32, 64, 1024, 8192). Field bits 4:3 pick the source (1 = internal prescaled clock). A channel with source 1 and a nonzero ratio code increments once per ratio cycles, so a match at value V from a start value of 0 comes V×ratio cycles after the clock-select write.
- R6: A channel holds its counter when its source field is 0 or 2, when its ratio code is 0, or when it is channel 1 with source 3.
- R7: Control bit 6 enables the compare-A pulse, bit 7 the compare-B pulse and bit 5 the overflow pulse. A pulse is one cycle wide, and it appears in the same cycle that the counter first shows the matching value. With its enable clear, a pulse never appears.
- R8: Control bits 4:3 choose clear-on-match (1 = compare A, 2 = compare B, 0 and 3 = none). A selected match clears the counter to 0 on that tick. A clear by A suppresses the B match and the overflow of that tick, and a clear by B suppresses the overflow.
- R9: When the counter wraps from its maximum to 0, an overflow pulse is emitted if enabled.
- R10: When channel 0's source is 3, the channels form a 16-bit counter {channel 0, channel 1} that advances on channel 1's prescaled tick and is compared with {A0, A1} and {B0, B1}. Channel 0's control register governs it and its pulses come out on the channel-0 interrupt bits. The channel-1 interrupt bits stay low.
- R11: A counter write wins over a count update in the same cycle, and no event comes from that cycle's tick.
- R12: Writing a channel's clock-select register restarts its prescaler, so the first tick after the write comes a full ratio period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_hw | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 4 | Register address {index, channel} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read request |
| irq_cma | output | 2 | Compare-A match pulse per channel |
| irq_cmb | output | 2 | Compare-B match pulse per channel |
| irq_ovf | output | 2 | Overflow pulse per channel |

## Verification
A register write takes effect at the next rising edge, and read data is registered, so it is due exactly one cycle after the request. An interrupt pulse follows the clock-select write by compare value times ratio cycles, and it lands in the cycle in which the counter shows the matched value. The bench drives on falling edges, samples on falling edges, and counts falling edges from the write until the pulse, comparing that count with the product worked out from R5 and R10. Hold and write-priority checks read the counter back in the cycle directly after the write, so a single stray increment shows up as a wrong value.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NCH   = 2;
  localparam int BYTEW = 8;
  localparam int PREW  = 13;

  localparam logic [2:0] RIX_CTL = 3'd0;
  localparam logic [2:0] RIX_CKR = 3'd1;
  localparam logic [2:0] RIX_CMA = 3'd2;
  localparam logic [2:0] RIX_CMB = 3'd3;
  localparam logic [2:0] RIX_CNT = 3'd4;
  localparam logic [2:0] RIX_STS = 3'd5;

  localparam logic [1:0] SRC_INT   = 2'd1;
  localparam logic [1:0] SRC_CHAIN = 2'd3;
  localparam logic [1:0] CLR_ON_A  = 2'd1;
  localparam logic [1:0] CLR_ON_B  = 2'd2;

  function automatic int unsigned div_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 8;
      3'd4:    return 32;
      3'd5:    return 64;
      3'd6:    return 1024;
      default: return 8192;
    endcase
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler import dct_pkg::*; #(
  parameter int PRE_W = PREW
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   limit;

  assign limit = (PRE_W+1)'(div_ratio(code));
  assign tick  = run && ({1'b0, pre_q} == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run || tick) pre_q <= '0;
    else                                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/dct_match.sv
module dct_match import dct_pkg::*; #(
  parameter int W = BYTEW
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   clr_sel,
  output logic [W-1:0] nxt,
  output logic         hit_a,
  output logic         hit_b,
  output logic         hit_ovf
);
  logic [W:0]   inc;
  logic [W-1:0] val;
  logic         eq_a, eq_b, clr_a, clr_b;

  always_comb begin
    inc     = {1'b0, cur} + 1'b1;
    val     = inc[W-1:0];
    eq_a    = (val == cmp_a);
    eq_b    = (val == cmp_b);
    clr_a   = eq_a && (clr_sel == CLR_ON_A);
    clr_b   = eq_b && (clr_sel == CLR_ON_B);
    hit_a   = eq_a;
    hit_b   = eq_b && !clr_a;
    hit_ovf = inc[W] && !clr_a && !clr_b;
    nxt     = (clr_a || clr_b) ? '0 : val;
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer import dct_pkg::*; #(
  parameter int PRE_W = PREW
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic        bus_hw,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [1:0]  irq_cma,
  output logic [1:0]  irq_cmb,
  output logic [1:0]  irq_ovf
);
  localparam int BW = BYTEW;
  localparam int HW = 2 * BW;
  localparam int NC = NCH;

  logic [2:0] idx;
  logic       chs, hw_ok, acc_ok, wr_go, rd_go;

  assign idx    = bus_addr[3:1];
  assign chs    = bus_addr[0];
  assign hw_ok  = !chs && (idx == RIX_CKR || idx == RIX_CMA ||
                           idx == RIX_CMB || idx == RIX_CNT);
  assign acc_ok = !bus_hw || hw_ok;
  assign wr_go  = bus_en && bus_we && acc_ok;
  assign rd_go  = bus_en && !bus_we;

  logic [BW-1:0] ctl_v [NC];
  logic [BW-1:0] ckr_v [NC];
  logic [BW-1:0] cma_v [NC];
  logic [BW-1:0] cmb_v [NC];
  logic [BW-1:0] cnt_v [NC];
  logic [BW-1:0] wd    [NC];
  logic [BW-1:0] rv    [NC];
  logic [NC-1:0] sel_ch, tick, cnt_wr;
  logic [1:0]    sts_q;

  logic          chain, chain_go, h16_a, h16_b, h16_o;
  logic [HW-1:0] nxt16;

  assign chain    = (ckr_v[0][4:3] == SRC_CHAIN);
  assign chain_go = chain && tick[1] && !(|cnt_wr);

  dct_match #(.W(HW)) u_chain (
    .cur    ({cnt_v[0], cnt_v[1]}),
    .cmp_a  ({cma_v[0], cma_v[1]}),
    .cmp_b  ({cmb_v[0], cmb_v[1]}),
    .clr_sel(ctl_v[0][4:3]),
    .nxt    (nxt16),
    .hit_a  (h16_a),
    .hit_b  (h16_b),
    .hit_ovf(h16_o)
  );

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [BW-1:0] ctl_q, ckr_q, cma_q, cmb_q, cnt_q, nxt8, slice16;
    logic          hit_a, hit_b, hit_o, run, go8;
    logic          ev_a, ev_b, ev_o, ia_q, ib_q, io_q;
    logic          wr_ctl, wr_ckr, wr_cma, wr_cmb;

    assign sel_ch[c] = bus_hw || (chs == 1'(c));
    assign wd[c]     = bus_hw ? bus_wdata[HW-1-c*BW -: BW] : bus_wdata[BW-1:0];
    assign wr_ctl    = wr_go && sel_ch[c] && idx == RIX_CTL;
    assign wr_ckr    = wr_go && sel_ch[c] && idx == RIX_CKR;
    assign wr_cma    = wr_go && sel_ch[c] && idx == RIX_CMA;
    assign wr_cmb    = wr_go && sel_ch[c] && idx == RIX_CMB;
    assign cnt_wr[c] = wr_go && sel_ch[c] && idx == RIX_CNT;

    assign run = (ckr_q[4:3] == SRC_INT) && (ckr_q[2:0] != 3'd0);

    dct_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(wr_ckr),
      .run    (run),
      .code   (ckr_q[2:0]),
      .tick   (tick[c])
    );

    dct_match #(.W(BW)) u_cmp (
      .cur    (cnt_q),
      .cmp_a  (cma_q),
      .cmp_b  (cmb_q),
      .clr_sel(ctl_q[4:3]),
      .nxt    (nxt8),
      .hit_a  (hit_a),
      .hit_b  (hit_b),
      .hit_ovf(hit_o)
    );

    assign go8     = !chain && tick[c] && !cnt_wr[c];
    assign slice16 = nxt16[HW-1-c*BW -: BW];
    assign ev_a    = go8 ? hit_a : ((c == 0) && chain_go && h16_a);
    assign ev_b    = go8 ? hit_b : ((c == 0) && chain_go && h16_b);
    assign ev_o    = go8 ? hit_o : ((c == 0) && chain_go && h16_o);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q <= '0;
        ckr_q <= '0;
        cma_q <= '1;
        cmb_q <= '1;
        cnt_q <= '0;
        ia_q  <= 1'b0;
        ib_q  <= 1'b0;
        io_q  <= 1'b0;
      end else begin
        if (wr_ctl) ctl_q <= wd[c] & 8'hF8;
        if (wr_ckr) ckr_q <= wd[c] & 8'h1F;
        if (wr_cma) cma_q <= wd[c];
        if (wr_cmb) cmb_q <= wd[c];
        if (cnt_wr[c])     cnt_q <= wd[c];
        else if (chain_go) cnt_q <= slice16;
        else if (go8)      cnt_q <= nxt8;
        ia_q <= ev_a && ctl_q[6];
        ib_q <= ev_b && ctl_q[7];
        io_q <= ev_o && ctl_q[5];
      end
    end

    assign ctl_v[c]   = ctl_q;
    assign ckr_v[c]   = ckr_q;
    assign cma_v[c]   = cma_q;
    assign cmb_v[c]   = cmb_q;
    assign cnt_v[c]   = cnt_q;
    assign irq_cma[c] = ia_q;
    assign irq_cmb[c] = ib_q;
    assign irq_ovf[c] = io_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= 2'b00;
    else if (wr_go && !bus_hw && !chs && idx == RIX_STS) sts_q <= wd[0][5:4];
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      case (idx)
        RIX_CTL: rv[c] = ctl_v[c];
        RIX_CKR: rv[c] = ckr_v[c];
        RIX_CMA: rv[c] = cma_v[c];
        RIX_CMB: rv[c] = cmb_v[c];
        RIX_CNT: rv[c] = cnt_v[c];
        RIX_STS: rv[c] = (c == 0) ? {2'b00, sts_q, 4'b0000} : 8'h10;
        default: rv[c] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (rd_go) begin
      if (!acc_ok)      bus_rdata <= '0;
      else if (bus_hw)  bus_rdata <= {rv[0], rv[1]};
      else              bus_rdata <= {8'h00, rv[chs]};
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       bus_we,
  input logic [1:0] irq_cma,
  input logic [1:0] irq_cmb,
  input logic [1:0] irq_ovf,
  input logic       chain,
  input logic [7:0] ctl0,
  input logic [7:0] ctl1,
  input logic [7:0] ckr1,
  input logic [7:0] cnt0,
  input logic [7:0] cnt1,
  input logic [7:0] cma1
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cma[0] |-> $past(ctl0[6])); // R7

  AST_CMA_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cma[1] |-> (cnt1 == $past(cma1) || cnt1 == 8'h00)); // R7

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf[0] |-> (cnt0 == 8'h00)); // R9

  AST_CLR_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cma[1] && irq_cmb[1]) |-> ($past(ctl1[4:3]) != 2'd1)); // R8

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ckr1[4:3] != 2'd1 && !(bus_en && bus_we)) |=> (cnt1 == $past(cnt1))); // R6

  AST_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chain |=> !(irq_cma[1] || irq_cmb[1] || irq_ovf[1])); // R10
endmodule

bind dual_cmp_timer dct_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bus_en (bus_en),
  .bus_we (bus_we),
  .irq_cma(irq_cma),
  .irq_cmb(irq_cmb),
  .irq_ovf(irq_ovf),
  .chain  (chain),
  .ctl0   (ctl_v[0]),
  .ctl1   (ctl_v[1]),
  .ckr1   (ckr_v[1]),
  .cnt0   (cnt_v[0]),
  .cnt1   (cnt_v[1]),
  .cma1   (cma_v[1])
);

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  localparam int CLK_P = 10;
  localparam int NV = 11;
  // {waddr, whw, wdata, raddr, rhw, expected}
  localparam logic [41:0] VEC [NV] = '{
    {4'd0,  1'b0, 16'h00FF, 4'd0,  1'b0, 16'h00F8},
    {4'd3,  1'b0, 16'h00E5, 4'd3,  1'b0, 16'h0005},
    {4'd4,  1'b1, 16'hABCD, 4'd4,  1'b0, 16'h00AB},
    {4'd12, 1'b0, 16'h0000, 4'd5,  1'b0, 16'h00CD},
    {4'd12, 1'b0, 16'h0000, 4'd4,  1'b1, 16'hABCD},
    {4'd0,  1'b1, 16'h1234, 4'd0,  1'b0, 16'h00F8},
    {4'd7,  1'b1, 16'h5555, 4'd7,  1'b0, 16'h00FF},
    {4'd11, 1'b0, 16'h00FF, 4'd11, 1'b0, 16'h0010},
    {4'd10, 1'b0, 16'h00FF, 4'd10, 1'b0, 16'h0030},
    {4'd12, 1'b0, 16'h0000, 4'd0,  1'b1, 16'h0000},
    {4'd9,  1'b1, 16'h0102, 4'd8,  1'b1, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we, bus_hw;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_cma, irq_cmb, irq_ovf;

  int   n_chk = 0;
  int   n_fail = 0;
  logic done = 1'b0;
  logic mon = 1'b0;
  logic seen1 = 1'b0;

  dual_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_hw(bus_hw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk)
    if (mon && (irq_cma[1] || irq_cmb[1] || irq_ovf[1])) seen1 = 1'b1;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic hw, input logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_hw = hw; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_hw = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic hw, output logic [15:0] q);
    bus_en = 1'b1; bus_we = 1'b0; bus_hw = hw; bus_addr = a;
    @(negedge clk);
    q = bus_rdata;
    bus_en = 1'b0; bus_hw = 1'b0;
  endtask

  function automatic logic pick(input int kind, input int ch);
    case (kind)
      0:       return irq_cma[ch];
      1:       return irq_cmb[ch];
      default: return irq_ovf[ch];
    endcase
  endfunction

  // cycles from the last write until the chosen pulse, -1 if none within lim
  task automatic wait_ev(input int kind, input int ch, input int lim, output int n);
    logic found;
    n = 0; found = 1'b0;
    while (!found && n < lim) begin
      @(negedge clk);
      n++;
      found = pick(kind, ch);
    end
    if (!found) n = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    int n;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_hw = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {26'd0, irq_cma, irq_cmb, irq_ovf}, 32'd0);
    rd(4'd0, 1'b0, q); chk("R1 ctl0", q, 16'h0000);
    rd(4'd1, 1'b0, q); chk("R1 ctl1", q, 16'h0000);
    rd(4'd2, 1'b1, q); chk("R1 ckr", q, 16'h0000);
    rd(4'd4, 1'b1, q); chk("R1 cma", q, 16'hFFFF);
    rd(4'd6, 1'b1, q); chk("R1 cmb", q, 16'hFFFF);
    rd(4'd8, 1'b1, q); chk("R1 cnt", q, 16'h0000);

    // R2 R3 R4 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][41:38], VEC[i][37], VEC[i][36:21]);
      rd(VEC[i][20:17], VEC[i][16], q);
      chk($sformatf("R2/R3/R4 table row %0d", i), q, VEC[i][15:0]);
    end
    wr(4'd0, 1'b0, 16'h0); wr(4'd3, 1'b0, 16'h0);
    wr(4'd4, 1'b1, 16'hFFFF); wr(4'd10, 1'b0, 16'h0);

    // R5 R7 ratio 2, match at 5
    wr(4'd1, 1'b0, 16'h40); wr(4'd5, 1'b0, 16'h05); wr(4'd3, 1'b0, 16'h0A);
    wait_ev(0, 1, 100, n); chk("R5 div2 match time", n, 10);
    @(negedge clk); chk("R7 pulse one cycle", irq_cma[1], 1'b0);
    wr(4'd3, 1'b0, 16'h00);
    repeat (10) @(negedge clk);
    rd(4'd9, 1'b0, q); chk("R6 hold after stop", q, 16'h0006);

    // R5 ratio 1
    wr(4'd9, 1'b0, 16'h00); wr(4'd3, 1'b0, 16'h09);
    wait_ev(0, 1, 100, n); chk("R5 div1 match time", n, 5);
    wr(4'd3, 1'b0, 16'h00);

    // R8 clear on A, B suppressed, period
    wr(4'd9, 1'b0, 16'h00); wr(4'd7, 1'b0, 16'h03); wr(4'd5, 1'b0, 16'h03);
    wr(4'd1, 1'b0, 16'hC8); wr(4'd3, 1'b0, 16'h09);
    wait_ev(0, 1, 50, n); chk("R8 first clear match", n, 3);
    chk("R8 B suppressed", irq_cmb[1], 1'b0);
    wait_ev(0, 1, 50, n); chk("R8 clear period", n, 3);
    wr(4'd3, 1'b0, 16'h00); wr(4'd7, 1'b0, 16'hFF); wr(4'd1, 1'b0, 16'h00);

    // R9 overflow
    wr(4'd0, 1'b0, 16'h20); wr(4'd8, 1'b0, 16'hFD); wr(4'd2, 1'b0, 16'h09);
    wait_ev(2, 0, 50, n); chk("R9 overflow time", n, 3);
    wr(4'd2, 1'b0, 16'h00);

    // R7 compare B pulse
    wr(4'd0, 1'b0, 16'h80); wr(4'd8, 1'b0, 16'hFD); wr(4'd2, 1'b0, 16'h09);
    wait_ev(1, 0, 50, n); chk("R7 cmb time", n, 2);
    wr(4'd2, 1'b0, 16'h00);

    // R7 enables clear: nothing
    wr(4'd0, 1'b0, 16'h00); wr(4'd8, 1'b0, 16'hFD); wr(4'd2, 1'b0, 16'h09);
    wait_ev(2, 0, 300, n); chk("R7 ovf disabled", n, 32'hFFFFFFFF);
    wait_ev(1, 0, 300, n); chk("R7 cmb disabled", n, 32'hFFFFFFFF);
    wait_ev(0, 0, 300, n); chk("R7 cma disabled", n, 32'hFFFFFFFF);
    wr(4'd2, 1'b0, 16'h00);

    // R8 clear on A at 0 suppresses overflow
    wr(4'd4, 1'b0, 16'h00); wr(4'd0, 1'b0, 16'h28);
    wr(4'd8, 1'b0, 16'hFD); wr(4'd2, 1'b0, 16'h09);
    wait_ev(2, 0, 300, n); chk("R8 overflow suppressed", n, 32'hFFFFFFFF);
    wr(4'd2, 1'b0, 16'h00); wr(4'd4, 1'b0, 16'hFF); wr(4'd0, 1'b0, 16'h00);

    // R11 write priority while running at ratio 1
    wr(4'd2, 1'b0, 16'h09);
    repeat (5) @(negedge clk);
    wr(4'd8, 1'b0, 16'h10);
    rd(4'd8, 1'b0, q); chk("R11 write wins", q, 16'h0010);
    wr(4'd2, 1'b0, 16'h00);

    // R6 stopped sources
    wr(4'd2, 1'b0, 16'h11); wr(4'd8, 1'b0, 16'h33);
    repeat (20) @(negedge clk);
    rd(4'd8, 1'b0, q); chk("R6 source 2 holds", q, 16'h0033);
    wr(4'd2, 1'b0, 16'h01);
    repeat (20) @(negedge clk);
    rd(4'd8, 1'b0, q); chk("R6 source 0 holds", q, 16'h0033);
    wr(4'd3, 1'b0, 16'h19); wr(4'd9, 1'b0, 16'h44);
    repeat (20) @(negedge clk);
    rd(4'd9, 1'b0, q); chk("R6 ch1 source 3 holds", q, 16'h0044);
    wr(4'd2, 1'b0, 16'h00); wr(4'd3, 1'b0, 16'h00);

    // R12 prescaler restart on clock-select write
    wr(4'd9, 1'b0, 16'h00); wr(4'd5, 1'b0, 16'h01); wr(4'd1, 1'b0, 16'h40);
    wr(4'd3, 1'b0, 16'h0C);
    repeat (20) @(negedge clk);
    wr(4'd3, 1'b0, 16'h0C);
    wait_ev(0, 1, 100, n); chk("R12 full period after rewrite", n, 32);
    wr(4'd3, 1'b0, 16'h00);

    // R10 cascade
    wr(4'd8, 1'b1, 16'h0000); wr(4'd4, 1'b1, 16'h0104);
    wr(4'd0, 1'b0, 16'h40); wr(4'd1, 1'b0, 16'hE0);
    seen1 = 1'b0; mon = 1'b1;
    wr(4'd2, 1'b1, 16'h1809);
    wait_ev(0, 0, 400, n); chk("R10 16-bit match time", n, 260);
    wr(4'd2, 1'b1, 16'h0000);
    mon = 1'b0;
    chk("R10 ch1 pulses quiet", seen1, 1'b0);
    rd(4'd8, 1'b1, q); chk("R10 16-bit count", q, 16'h0105);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule